// File: doc/BRIEF.md
# Banked Register File Address Unit

This block holds the data registers of a small 8-bit controller and works out where each access lands in a 64-location register space. Locations 01h–1Fh are one shared set. Locations 20h–3Fh exist four times over, once per bank. A select register at 04h does two jobs. Its two top bits name the active bank, and its six low bits hold a pointer used for indirect accesses. When no indirection is used, the select register is simply an 8-bit storage byte.

An access is a request on a valid/ready channel. The request carries a direct address, an indirect flag, a write flag and write data. A read produces one response on a second valid/ready channel. The response register is one deep. A new request is refused while an undelivered response is pending and the consumer is not taking it that cycle. Writes complete when they are accepted and produce no response.

A separate bank command loads the bank bits in one step, without a read-modify-write of the select register. It takes effect from the next clock edge.

Top module: `banked_rf`

## Requirements
- R1: After reset the select register reads 00h (bank 0, pointer 00h) and `rsp_valid` is 0.
- R2: Addresses 01h–1Fh, apart from 04h, reach the same storage whichever bank is selected.
- R3: Addresses 20h–3Fh reach storage chosen by select bits 7:6. The values 00, 01, 10 and 11 pick banks 0, 1, 2 and 3, and the four banks are independent.
- R4: The select register sits at address 04h and can be read and written at its full 8 bits. Bits 7:6 hold the bank and bits 5:0 hold the pointer.
- R5: An access is indirect when `req_ind` is 1 or `req_addr` is 00h. An indirect access uses select bits 5:0 as its address and ignores `req_addr`. Banking applies to that address in the same way as to a direct one, and a pointer of 04h reaches the select register.
- R6: An indirect access whose pointer is 00h reads as 00h. A write through it changes nothing.
- R7: When `bank_set` is 1 at a clock edge, that edge loads `bank_num` into select bits 7:6 and leaves bits 5:0 unchanged. A request accepted at the same edge still uses the old bank. If a write to the select register is accepted at the same edge, `bank_num` sets bits 7:6 and the write data sets bits 5:0.
- R8: A read accepted at a clock edge sets `rsp_valid` with its data at that edge. `rsp_valid` and `rsp_rdata` then hold unchanged until an edge at which `rsp_ready` is 1.
- R9: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. An accepted write produces no response. A read accepted at the following edge sees the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ind | input | 1 | Force indirect access through the pointer |
| req_addr | input | 6 | Direct register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8 | Read response data |
| bank_set | input | 1 | Bank command strobe |
| bank_num | input | 2 | Bank to load by the command |

## Verification
A read's data appears on the response port one rising edge after it is accepted. A write, like a bank command, affects only requests accepted at later edges. The bench drives every request and command on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The same-edge cases (a bank command beside a read, and a bank command beside a select-register write) are placed in a single driven cycle so that the old-versus-new bank outcome can be told apart.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 6;
  localparam int BANK_W   = 2;
  localparam int SEL_ADDR = 4;

  typedef struct packed {
    logic hit_sel;
    logic hit_null;
  } target_t;
endpackage

// File: rtl/bank_resolve.sv
module bank_resolve
  import banked_rf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BANK_W,
  parameter int IW = 8,
  parameter int SELA = SEL_ADDR
) (
  input  logic [AW-1:0]    addr,
  input  logic             ind,
  input  logic [BW-1:0]    bank,
  input  logic [AW-1:0]    ptr,
  output target_t          tgt,
  output logic [IW-1:0]    idx
);
  localparam int LOW = 2 ** (AW - 1);

  logic          use_ptr;
  logic [AW-1:0] eff;

  always_comb begin
    use_ptr      = ind || (addr == '0);
    eff          = use_ptr ? ptr : addr;
    tgt.hit_null = use_ptr && (ptr == '0);
    tgt.hit_sel  = !tgt.hit_null && (eff == AW'(SELA));
    if (eff[AW-1])
      idx = IW'(LOW) + IW'({bank, eff[AW-2:0]});
    else
      idx = IW'(eff);
  end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 160,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/banked_rf.sv
module banked_rf
  import banked_rf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_ind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic          bank_set,
  input  logic [BW-1:0] bank_num
);
  localparam int LOW   = 2 ** (AW - 1);
  localparam int DEPTH = LOW + (2 ** BW) * LOW;
  localparam int IW    = $clog2(DEPTH);

  logic [DW-1:0] sel_q;
  target_t       tgt;
  logic [IW-1:0] idx;
  logic [DW-1:0] store_rd;
  logic [DW-1:0] rd_mux;
  logic          accept;
  logic          store_we;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign store_we  = accept && req_write && !tgt.hit_null && !tgt.hit_sel;

  bank_resolve #(.AW(AW), .BW(BW), .IW(IW), .SELA(SEL_ADDR)) u_resolve (
    .addr (req_addr),
    .ind  (req_ind),
    .bank (sel_q[DW-1 -: BW]),
    .ptr  (sel_q[AW-1:0]),
    .tgt  (tgt),
    .idx  (idx)
  );

  byte_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk   (clk),
    .we    (store_we),
    .idx   (idx),
    .wdata (req_wdata),
    .rdata (store_rd)
  );

  always_comb begin
    if (tgt.hit_null)     rd_mux = '0;
    else if (tgt.hit_sel) rd_mux = sel_q;
    else                  rd_mux = store_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      if (accept && req_write && tgt.hit_sel) sel_q <= req_wdata;
      if (bank_set) sel_q[DW-1 -: BW] <= bank_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rsp_valid <= 1'b0;
    else if (accept && !req_write) rsp_valid <= 1'b1;
    else if (rsp_ready)          rsp_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept && !req_write) rsp_rdata <= rd_mux;
  end
endmodule

// File: rtl/banked_rf_chk.sv
module banked_rf_chk #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          req_ind,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata,
  input logic          bank_set,
  input logic [BW-1:0] bank_num,
  input logic [DW-1:0] sel_q
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R8
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  // R9
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);

  // R7
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_set |=> sel_q[DW-1 -: BW] == $past(bank_num));

  // R6
  null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && (req_ind || req_addr == '0)
      && sel_q[AW-1:0] == '0 |=> rsp_rdata == '0);
endmodule

bind banked_rf banked_rf_chk #(.DW(DW), .AW(AW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_ind   (req_ind),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .bank_set  (bank_set),
  .bank_num  (bank_num),
  .sel_q     (sel_q)
);

// File: tb/tb_banked_rf.sv
module tb_banked_rf;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0, req_write = 0, req_ind = 0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid;
  logic       rsp_ready = 1;
  logic [7:0] rsp_rdata;
  logic       bank_set = 0;
  logic [1:0] bank_num = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_sh [64];
  logic [7:0] m_bk [4][32];
  logic [7:0] d;

  always #5 clk = ~clk;

  banked_rf dut (.*);

  function automatic logic [7:0] seed(int b, int a);
    return 8'((a * 7 + b * 61 + 3) & 8'hFF);
  endfunction

  function automatic logic [7:0] model(int b, int a);
    if (a < 32) return m_sh[a];
    return m_bk[b][a-32];
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic ind, logic [7:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_ind = ind; req_addr = a; req_wdata = v;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_ind = 0;
  endtask

  task automatic rd(logic [5:0] a, logic ind, output logic [7:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_ind = ind; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_ind = 0;
    check("R8 rsp_valid", {7'b0, rsp_valid}, 8'd1);
    v = rsp_rdata;
  endtask

  task automatic setbank(int b);
    @(negedge clk);
    bank_set = 1; bank_num = 2'(b);
    @(negedge clk);
    bank_set = 0;
  endtask

  task automatic sweep_direct(string tag);
    for (int b = 0; b < 4; b++) begin
      setbank(b);
      for (int a = 1; a < 64; a++) begin
        rd(6'(a), 0, d);
        if (a == 4) check({tag, " R4 sel"}, d, {2'(b), 6'd0});
        else        check({tag, a < 32 ? " R2" : " R3"}, d, model(b, a));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 rsp_valid", {7'b0, rsp_valid}, 8'd0);
    rd(6'd4, 0, d);
    check("R1 sel reset", d, 8'h00);

    // initialise: shared once, each bank separately
    for (int b = 0; b < 4; b++) begin
      setbank(b);
      for (int a = 1; a < 64; a++) begin
        if (a == 4 || (a < 32 && b != 0)) continue;
        wr(6'(a), 0, seed(b, a));
        if (a < 32) m_sh[a] = seed(b, a);
        else        m_bk[b][a-32] = seed(b, a);
      end
    end
    sweep_direct("init");

    // R5 indirect reads through pointer, both flag and address 00h
    for (int b = 0; b < 4; b++) begin
      for (int p = 1; p < 64; p++) begin
        wr(6'd4, 0, {2'(b), 6'(p)});
        rd((p % 2) ? 6'h2A : 6'h00, p % 2 == 1, d);
        if (p == 4) check("R5 ind sel", d, {2'(b), 6'(p)});
        else        check("R5 ind read", d, model(b, p));
      end
    end

    // R5 indirect writes, checked by direct reads
    for (int b = 0; b < 4; b++) begin
      for (int p = 1; p < 64; p++) begin
        if (p == 4) continue;
        wr(6'd4, 0, {2'(b), 6'(p)});
        wr(6'h11, 1, ~seed(b, p) ^ 8'(b));
        if (p < 32) m_sh[p] = ~seed(b, p) ^ 8'(b);
        else        m_bk[b][p-32] = ~seed(b, p) ^ 8'(b);
      end
    end
    wr(6'd4, 0, 8'h00);
    sweep_direct("indwr");

    // R6 null pointer
    for (int b = 0; b < 4; b++) begin
      wr(6'd4, 0, {2'(b), 6'd0});
      wr(6'h00, 0, 8'h5A);
      wr(6'h33, 1, 8'hA5);
      rd(6'h00, 0, d);
      check("R6 null read addr0", d, 8'h00);
      rd(6'h2F, 1, d);
      check("R6 null read flag", d, 8'h00);
      rd(6'd4, 0, d);
      check("R6 sel unchanged", d, {2'(b), 6'd0});
    end
    sweep_direct("R6 after");

    // R7 bank command same edge as a read uses old bank
    setbank(1);
    @(negedge clk);
    bank_set = 1; bank_num = 2'd2;
    req_valid = 1; req_write = 0; req_addr = 6'h25;
    @(negedge clk);
    bank_set = 0; req_valid = 0;
    check("R7 old bank read", rsp_rdata, model(1, 6'h25));
    rd(6'h25, 0, d);
    check("R7 new bank read", d, model(2, 6'h25));
    // R7 command and select write at same edge
    @(negedge clk);
    bank_set = 1; bank_num = 2'd3;
    req_valid = 1; req_write = 1; req_addr = 6'd4; req_wdata = 8'h07;
    @(negedge clk);
    bank_set = 0; req_valid = 0; req_write = 0;
    rd(6'd4, 0, d);
    check("R7 merge", d, 8'hC7);
    // R7 bank command keeps pointer bits
    setbank(1);
    rd(6'd4, 0, d);
    check("R7 keep ptr", d, 8'h47);

    // R9 write then immediate read
    wr(6'h3E, 0, 8'hE1);
    rd(6'h3E, 0, d);
    check("R9 write visible", d, 8'hE1);
    m_bk[1][30] = 8'hE1;

    // R8/R9 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 6'h3E;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 3; i++) begin
      check("R8 held valid", {7'b0, rsp_valid}, 8'd1);
      check("R8 held data", rsp_rdata, 8'hE1);
      check("R9 ready low", {7'b0, req_ready}, 8'd0);
      req_valid = 1; req_addr = 6'h01;
      @(negedge clk);
    end
    req_valid = 0;
    check("R8 still held", rsp_rdata, 8'hE1);
    rsp_ready = 1;
    #1 check("R9 ready with consumer", {7'b0, req_ready}, 8'd1);
    @(negedge clk);
    check("R8 released", {7'b0, rsp_valid}, 8'd0);
    check("R9 ready idle", {7'b0, req_ready}, 8'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule